// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every valid cycle on a processor bus and raises a break request when the configured conditions are met. It has two comparison channels, A and B. Each channel checks the cycle's address under a coded low-bit mask, an 8-bit address-space identifier that can be ignored, and three cycle qualifiers: access size, direction, and instruction or data fetch. Channel B can also compare the bus data against a reference value. A per-bit data mask decides which bits take part.

A control register selects one of two modes. In independent mode, either channel alone can trigger. In sequential mode, a channel A hit arms channel B, and only a later B hit triggers. The control register also holds a sticky hit flag for each channel and a before/after-execution tag for each channel. The processor uses that tag to decide where the break is taken. Software sets everything up through a simple synchronous register port.

Register offsets on `reg_addr`:

| Offset | Register |
|---|---|
| 0 | A address |
| 1 | A mask |
| 2 | A identifier |
| 3 | A cycle |
| 4 | B address |
| 5 | B mask |
| 6 | B identifier |
| 7 | B cycle |
| 8 | B data |
| 9 | B data mask |
| 10 | control |

Unused offsets read as zero.

Top module: `bus_break_cmp`

## Requirements
- R1: The address mask code is formed from mask register bits {3,1,0}. Code 0x00 compares all 32 bits. 0x01 ignores bits [9:0]. 0x02 ignores bits [11:0]. 0x08 ignores bits [15:0]. 0x09 ignores bits [19:0]. 0x03 ignores every address bit.
- R2: Bit 2 (0x04) of a channel's mask register makes that channel skip the identifier comparison. When the bit is clear, `bus_asid` must equal the channel's identifier register.
- R3: The size qualifier is formed from cycle register bits {6,1,0}. Code 0 accepts any size. 0x01 accepts 8-bit only, 0x02 accepts 16-bit only, 0x03 accepts 32-bit only and 0x40 accepts 64-bit only. On the bus, `bus_size` codes are 0=8, 1=16, 2=32 and 3=64 bits.
- R4: Cycle bit 0x04 accepts reads and cycle bit 0x08 accepts writes. With both set, either direction matches. With neither set, the channel never matches.
- R5: Cycle bit 0x10 accepts instruction fetches and cycle bit 0x20 accepts data accesses. With both set, either type matches. With neither set, the channel never matches.
- R6: When control bit 0x0080 is set, channel B also requires equality of `bus_data` with its data register. Only bits whose data-mask bit is 0 are compared. When the bit is clear, the data value has no effect.
- R7: With control bit 0x0008 clear, a hit on A or B fires a break. When both hit in the same cycle, the tag comes from channel A.
- R8: With control bit 0x0008 set, an A hit arms channel B. A later B hit while armed fires a break and disarms. A B hit while not armed does nothing. Any write to the control register disarms.
- R9: Control bits 0x8000 (A) and 0x4000 (B) are set by a channel hit and stay set. A software write of 0 clears a flag and a write of 1 leaves it unchanged. Only bits 0x0008, 0x0040, 0x0080, 0x0400 and the two flags are stored.
- R10: `brk_req` is a one-cycle pulse in the cycle after the triggering bus cycle. `brk_after` comes from the causing channel's tag: control bit 0x0400 for A, 0x0040 for B. `brk_after` is low when no break fires.
- R11: After reset all registers read 0 and `brk_req` is low. With all registers at 0, no bus cycle can match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 32 | Cycle address |
| bus_asid | input | 8 | Cycle address-space identifier |
| bus_size | input | 2 | Cycle size code |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_insn | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_data | input | 32 | Cycle data |
| brk_req | output | 1 | Break request pulse |
| brk_after | output | 1 | Break taken after the instruction |

## Verification
A fixed two-channel setup is driven with a table of bus cycles. Each entry differs from a hitting cycle in exactly one field: an address bit just above or below the mask boundary, the identifier, the size, the direction, the fetch type, or one unmasked data bit. A wrong break therefore points to one comparator term. Directed sequences then step through every mask code at its boundary bit and both modes. They cover a same-cycle hit on both channels to expose the tag priority, and the arm/disarm order in sequential mode, including disarming through a control write. Flag stickiness is read back after write-one and write-zero patterns.

// File: rtl/bus_break_cmp.sv
module bus_break_cmp #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [IW-1:0] bus_asid,
  input  logic [1:0]    bus_size,
  input  logic          bus_write,
  input  logic          bus_insn,
  input  logic [DW-1:0] bus_data,
  output logic          brk_req,
  output logic          brk_after
);
  localparam logic [3:0] O_AADR = 4'd0, O_AMSK = 4'd1, O_AID = 4'd2, O_ACYC = 4'd3,
                         O_BADR = 4'd4, O_BMSK = 4'd5, O_BID = 4'd6, O_BCYC = 4'd7,
                         O_BDAT = 4'd8, O_BDMK = 4'd9, O_CTRL = 4'd10;
  localparam logic [15:0] CTRL_KEEP = 16'h04C8;

  logic [AW-1:0] a_adr, b_adr;
  logic [7:0]    a_msk, b_msk, a_cyc, b_cyc;
  logic [IW-1:0] a_id, b_id;
  logic [DW-1:0] b_dat, b_dmk;
  logic [15:0]   ctrl;
  logic          armed;

  function automatic logic adr_ok(input logic [AW-1:0] r, a, input logic [7:0] m);
    logic [AW-1:0] ign;
    case ({m[3], m[1], m[0]})
      3'b000:  ign = '0;
      3'b001:  ign = AW'((64'd1 << 10) - 1);
      3'b010:  ign = AW'((64'd1 << 12) - 1);
      3'b100:  ign = AW'((64'd1 << 16) - 1);
      3'b101:  ign = AW'((64'd1 << 20) - 1);
      default: ign = '1;
    endcase
    return ((r ^ a) & ~ign) == '0;
  endfunction

  function automatic logic cyc_ok(input logic [7:0] c, input logic [1:0] sz, input logic wr, ins);
    logic s;
    case ({c[6], c[1:0]})
      3'b000:  s = 1'b1;
      3'b001:  s = (sz == 2'd0);
      3'b010:  s = (sz == 2'd1);
      3'b011:  s = (sz == 2'd2);
      3'b100:  s = (sz == 2'd3);
      default: s = 1'b0;
    endcase
    return s && (wr ? c[3] : c[2]) && (ins ? c[4] : c[5]);
  endfunction

  wire hit_a = bus_valid && adr_ok(a_adr, bus_addr, a_msk) &&
               (a_msk[2] || a_id == bus_asid) && cyc_ok(a_cyc, bus_size, bus_write, bus_insn);
  wire hit_b = bus_valid && adr_ok(b_adr, bus_addr, b_msk) &&
               (b_msk[2] || b_id == bus_asid) && cyc_ok(b_cyc, bus_size, bus_write, bus_insn) &&
               (!ctrl[7] || ((b_dat ^ bus_data) & ~b_dmk) == '0);

  wire seq     = ctrl[3];
  wire ctrl_wr = reg_we && reg_addr == O_CTRL;
  wire fire    = seq ? (hit_b && armed) : (hit_a || hit_b);
  wire tag     = (!seq && hit_a) ? ctrl[10] : ctrl[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_adr <= '0; b_adr <= '0; a_msk <= '0; b_msk <= '0; a_cyc <= '0; b_cyc <= '0;
      a_id <= '0; b_id <= '0; b_dat <= '0; b_dmk <= '0; ctrl <= '0;
      armed <= 1'b0; brk_req <= 1'b0; brk_after <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          O_AADR: a_adr <= reg_wdata[AW-1:0];
          O_AMSK: a_msk <= reg_wdata[7:0];
          O_AID:  a_id  <= reg_wdata[IW-1:0];
          O_ACYC: a_cyc <= reg_wdata[7:0];
          O_BADR: b_adr <= reg_wdata[AW-1:0];
          O_BMSK: b_msk <= reg_wdata[7:0];
          O_BID:  b_id  <= reg_wdata[IW-1:0];
          O_BCYC: b_cyc <= reg_wdata[7:0];
          O_BDAT: b_dat <= reg_wdata[DW-1:0];
          O_BDMK: b_dmk <= reg_wdata[DW-1:0];
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        ctrl[13:0] <= reg_wdata[13:0] & CTRL_KEEP[13:0];
        ctrl[15]   <= (ctrl[15] & reg_wdata[15]) | hit_a;
        ctrl[14]   <= (ctrl[14] & reg_wdata[14]) | hit_b;
      end else begin
        ctrl[15] <= ctrl[15] | hit_a;
        ctrl[14] <= ctrl[14] | hit_b;
      end
      if (!seq || ctrl_wr || fire) armed <= 1'b0;
      else if (hit_a)              armed <= 1'b1;
      brk_req   <= fire;
      brk_after <= fire && tag;
    end
  end

  always_comb begin
    case (reg_addr)
      O_AADR:  reg_rdata = 32'(a_adr);
      O_AMSK:  reg_rdata = {24'd0, a_msk};
      O_AID:   reg_rdata = 32'(a_id);
      O_ACYC:  reg_rdata = {24'd0, a_cyc};
      O_BADR:  reg_rdata = 32'(b_adr);
      O_BMSK:  reg_rdata = {24'd0, b_msk};
      O_BID:   reg_rdata = 32'(b_id);
      O_BCYC:  reg_rdata = {24'd0, b_cyc};
      O_BDAT:  reg_rdata = 32'(b_dat);
      O_BDMK:  reg_rdata = 32'(b_dmk);
      O_CTRL:  reg_rdata = {16'd0, ctrl};
      default: reg_rdata = '0;
    endcase
  end

  a_r10_tag_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> !brk_after);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !$past(bus_valid, 2) |-> !$past(brk_req));
  a_r8_seq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && $past(seq) |-> $past(armed));
  a_r9_flag_a_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl[15]) && !$past(ctrl_wr) |-> ctrl[15]);
  a_r9_flag_b_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl[14]) && !$past(ctrl_wr) |-> ctrl[14]);
  a_r7_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (ctrl[15] || ctrl[14]));
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !brk_req);
endmodule

// File: tb/tb_bus_break_cmp.sv
`timescale 1ns/1ps
module tb_bus_break_cmp;
  logic clk = 0, rst_n = 0, reg_we = 0, bus_valid = 0, bus_write = 0, bus_insn = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, bus_addr = 0, bus_data = 0;
  logic [7:0] bus_asid = 0;
  logic [1:0] bus_size = 0;
  logic brk_req, brk_after;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_break_cmp dut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .bus_valid, .bus_addr, .bus_asid, .bus_size, .bus_write, .bus_insn, .bus_data,
    .brk_req, .brk_after);

  task automatic chk(input string r, input logic [31:0] got, exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cyc(input logic [31:0] a, input logic [7:0] id, input logic [1:0] sz,
                     input logic w, i, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_asid = id; bus_size = sz; bus_write = w; bus_insn = i; bus_data = d;
    bus_valid = 1;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic expect_brk(input string r, input logic b, af);
    chk(r, {31'd0, brk_req}, {31'd0, b});
    chk(r, {31'd0, brk_after}, {31'd0, af});
  endtask

  // addr, asid, size, write, insn, data, brk, after
  localparam logic [77:0] VEC [9] = '{
    {32'h12345ABC, 8'd5, 2'd0, 1'b0, 1'b1, 32'h0,        1'b1, 1'b0},
    {32'h12346000, 8'd5, 2'd0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b0},
    {32'h12345000, 8'd6, 2'd0, 1'b0, 1'b1, 32'h0,        1'b0, 1'b0},
    {32'h80000000, 8'd9, 2'd2, 1'b1, 1'b0, 32'hDEAD1234, 1'b1, 1'b1},
    {32'h80000000, 8'd9, 2'd2, 1'b1, 1'b0, 32'hDEAC1234, 1'b0, 1'b0},
    {32'h80000000, 8'd9, 2'd2, 1'b0, 1'b0, 32'hDEAD1234, 1'b0, 1'b0},
    {32'h80000000, 8'd9, 2'd1, 1'b1, 1'b0, 32'hDEAD1234, 1'b0, 1'b0},
    {32'h80000000, 8'd9, 2'd2, 1'b1, 1'b1, 32'hDEAD1234, 1'b0, 1'b0},
    {32'h80000004, 8'd9, 2'd2, 1'b1, 1'b0, 32'hDEAD1234, 1'b0, 1'b0}
  };
  localparam string VTAG [9] = '{"R1", "R1", "R2", "R6", "R6", "R4", "R3", "R5", "R1"};

  task automatic a_probe(input string r, input logic [31:0] a, input logic exp);
    cyc(a, 8'd5, 2'd0, 1'b0, 1'b0, 32'h0);
    expect_brk(r, exp, 1'b0);
  endtask

  logic [31:0] d;
  logic [31:0] bhit_a = 32'h80000000, bhit_d = 32'hDEAD1234;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    rd(4'd10, d); chk("R11 ctrl", d, 0);
    rd(4'd0, d);  chk("R11 a_addr", d, 0);
    cyc(32'h0, 8'd0, 2'd0, 1'b0, 1'b1, 32'h0);
    expect_brk("R11 no match at reset", 0, 0);

    wr(4'd0, 32'h12345000); wr(4'd1, 32'h02); wr(4'd2, 32'h05); wr(4'd3, 32'h3C);
    wr(4'd4, 32'h80000000); wr(4'd5, 32'h04); wr(4'd7, 32'h2B);
    wr(4'd8, 32'hDEADBEEF); wr(4'd9, 32'h0000FFFF); wr(4'd10, 32'h00C0);

    foreach (VEC[k]) begin
      cyc(VEC[k][77:46], VEC[k][45:38], VEC[k][37:36], VEC[k][35], VEC[k][34], VEC[k][33:2]);
      expect_brk(VTAG[k], VEC[k][1], VEC[k][0]);
      @(negedge clk);
      chk("R10 pulse ends", {31'd0, brk_req}, 0);
    end

    // R9 sticky flags
    rd(4'd10, d); chk("R9 both flags set", d, 32'hC0C0);
    wr(4'd10, 32'hC0C0); rd(4'd10, d); chk("R9 write 1 keeps", d, 32'hC0C0);
    wr(4'd10, 32'h40C0); rd(4'd10, d); chk("R9 clear A only", d, 32'h40C0);
    wr(4'd10, 32'hFFFF); rd(4'd10, d); chk("R9 unstored bits", d, 32'h44C8);
    wr(4'd10, 32'h00C0); rd(4'd10, d); chk("R9 clear B", d, 32'h00C0);

    // R6 data compare disabled
    wr(4'd10, 32'h0040);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, 32'h00000000);
    expect_brk("R6 data ignored", 1, 1);

    // R1 mask codes
    wr(4'd1, 32'h00); a_probe("R1 code00 bit0", 32'h12345001, 0);
    a_probe("R1 code00 exact", 32'h12345000, 1);
    wr(4'd1, 32'h01); a_probe("R1 code01 bit9", 32'h12345200, 1);
    a_probe("R1 code01 bit10", 32'h12345400, 0);
    wr(4'd1, 32'h08); a_probe("R1 code08 bit15", 32'h1234D000, 1);
    a_probe("R1 code08 bit16", 32'h12355000, 0);
    wr(4'd1, 32'h09); a_probe("R1 code09 bit19", 32'h123D5000, 1);
    a_probe("R1 code09 bit20", 32'h12245000, 0);
    wr(4'd1, 32'h03); a_probe("R1 code03 all", 32'hEDCBAFFF, 1);

    // R2 identifier ignore
    wr(4'd1, 32'h06);
    cyc(32'h12345000, 8'd6, 2'd0, 1'b0, 1'b0, 0); expect_brk("R2 id ignored", 1, 0);
    wr(4'd1, 32'h02);
    cyc(32'h12345000, 8'd6, 2'd0, 1'b0, 1'b0, 0); expect_brk("R2 id compared", 0, 0);

    // R3 size
    wr(4'd3, 32'h7C);
    cyc(32'h12345000, 8'd5, 2'd3, 1'b0, 1'b0, 0); expect_brk("R3 64 hit", 1, 0);
    cyc(32'h12345000, 8'd5, 2'd2, 1'b0, 1'b0, 0); expect_brk("R3 64 vs 32", 0, 0);
    wr(4'd3, 32'h3D);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b0, 0); expect_brk("R3 8 hit", 1, 0);

    // R4 direction
    wr(4'd3, 32'h30);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b1, 1'b0, 0); expect_brk("R4 none write", 0, 0);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b0, 0); expect_brk("R4 none read", 0, 0);
    wr(4'd3, 32'h34);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b1, 1'b0, 0); expect_brk("R4 read-only write", 0, 0);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b0, 0); expect_brk("R4 read-only read", 1, 0);

    // R5 fetch type
    wr(4'd3, 32'h14);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b0, 0); expect_brk("R5 insn-only data", 0, 0);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b1, 0); expect_brk("R5 insn-only insn", 1, 0);
    wr(4'd3, 32'h0C);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b1, 0); expect_brk("R5 no type", 0, 0);

    // R7 both hit, A tag wins
    wr(4'd1, 32'h07); wr(4'd3, 32'h3C); wr(4'd10, 32'h00C0);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, bhit_d); expect_brk("R7 both A tag 0", 1, 0);
    wr(4'd10, 32'h0480);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, bhit_d); expect_brk("R7 both A tag 1", 1, 1);

    // R8 sequential
    wr(4'd1, 32'h02); wr(4'd10, 32'h00C8);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, bhit_d); expect_brk("R8 B unarmed", 0, 0);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b0, 0); expect_brk("R8 A arms only", 0, 0);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, bhit_d); expect_brk("R8 B armed fires", 1, 1);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, bhit_d); expect_brk("R8 disarmed", 0, 0);
    cyc(32'h12345000, 8'd5, 2'd0, 1'b0, 1'b0, 0);
    wr(4'd10, 32'h00C8);
    cyc(bhit_a, 8'd9, 2'd2, 1'b1, 1'b0, bhit_d); expect_brk("R8 ctrl write disarms", 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10 got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule